// File: doc/BRIEF.md
# Back-End Credit Limiter

This block sits beside one thread's rename stage and decides, every cycle, how many instructions rename may hand to the back end. It keeps a stored free-entry count for each of three back-end structures: the reorder buffer (ROB), the issue queue (IQ) and the load/store queue (LSQ). It also counts instructions that rename has already passed on but that the back end has not yet dispatched. The credit for a structure is its free count less those in-flight instructions. Instructions that the back end reports as dispatched in the current cycle are given back first. The LSQ uses its own dispatched count.

The smallest of the three credits bounds the grant, and the per-cycle rename width caps it further. When the grant falls short of the instructions on offer, the block raises a block flag. When a back-end structure caused the shortfall, it also counts a full event against the structure that set the limit. Instruction storage is not part of this block: the surrounding stage removes the granted number of instructions from its own queue.

Top module: `cred_limiter`

## Requirements
- R1: After reset the in-flight count and all three full-event counters are 0, the stored ROB-empty flag is 1, and the stored free counts take their parameter values (default ROB 32, IQ 16, LSQ 8).
- R2: ROB credit is the effective ROB free count minus (in-flight count minus `disp_cnt`). IQ credit is formed the same way from the IQ free count. Credits are signed and negative values do not wrap.
- R3: LSQ credit is the effective LSQ free count minus (in-flight count minus `disp_lsq_cnt`).
- R4: The limiting resource, `lim_src`, starts as ROB (code 0). IQ (code 1) replaces it only when the IQ credit is strictly lower. LSQ (code 2) then replaces it only when the LSQ credit is strictly lower than the value kept so far. Code 3 never appears.
- R5: With `avail_cnt` non-zero and the minimum credit at or below zero, the grant is 0, `block` is 1, and the limiting resource's full-event counter increments by one at the next edge.
- R6: With the minimum credit positive but below `avail_cnt`, the grant equals that credit (before the width cap), `block` is 1, and the limiting resource's counter increments.
- R7: The grant never exceeds RENAME_W (default 4). When only the width cap stops the grant short of `avail_cnt`, `block` is 1 and no counter moves.
- R8: With `avail_cnt` at 0, the grant is 0, `block` is 0 and no counter moves.
- R9: At each edge the in-flight count becomes its old value plus `grant_cnt` minus `disp_cnt`.
- R10: When that sum would fall below zero, `underflow_err` is 1 in that cycle and the in-flight count becomes 0.
- R11: A free-count update with its valid flag set is used for credit in the same cycle and is stored. When the valid flag is clear, the update's count is ignored. The ROB-empty flag is stored only with the ROB valid flag and appears on `rob_empty` from the next cycle.
- R12: With EVT_SAT=1 (default), each full-event counter stops at its maximum value, 2^EVT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rob_upd_vld | input | 1 | ROB free-count update valid |
| rob_upd_cnt | input | CNT_W | New ROB free count |
| rob_upd_empty | input | 1 | ROB-empty flag carried with the ROB update |
| iq_upd_vld | input | 1 | IQ free-count update valid |
| iq_upd_cnt | input | CNT_W | New IQ free count |
| lsq_upd_vld | input | 1 | LSQ free-count update valid |
| lsq_upd_cnt | input | CNT_W | New LSQ free count |
| disp_cnt | input | CNT_W | Instructions dispatched this cycle |
| disp_lsq_cnt | input | CNT_W | Instructions dispatched to the LSQ this cycle |
| avail_cnt | input | CNT_W | Instructions waiting to be renamed |
| grant_cnt | output | GNT_W | Instructions that may be renamed this cycle |
| block | output | 1 | Grant is below the available count |
| lim_src | output | 2 | Limiting resource: 0 ROB, 1 IQ, 2 LSQ |
| rob_empty | output | 1 | Stored ROB-empty flag |
| inflight | output | CNT_W | Renamed but not yet dispatched count |
| rob_full_evt | output | EVT_W | ROB full-event counter |
| iq_full_evt | output | EVT_W | IQ full-event counter |
| lsq_full_evt | output | EVT_W | LSQ full-event counter |
| underflow_err | output | 1 | In-flight count would have gone negative |

## Verification
The main function is driven through a sequence in which each of the three structures becomes the bottleneck in turn. A plentiful-credit cycle separates a correct grant from one wrongly clamped. A credit exactly equal to the available count separates a strict comparison from a non-strict one. Zero and negative credits separate signed from unsigned arithmetic. Three-way and two-way ties pin down the tie-break order. Cycles that pair a non-zero total dispatch with a different LSQ dispatch tell apart which count each credit subtracts. Updates carrying a clear valid flag with extreme counts show whether stale or fresh values are in use. Oversized dispatch exposes the underflow clamp. A long stall run saturates a counter.

// File: rtl/cred_pkg.sv
package cred_pkg;
   localparam int NUM_RES = 3;

   typedef enum logic [1:0] {
      SRC_ROB = 2'd0,
      SRC_IQ  = 2'd1,
      SRC_LSQ = 2'd2
   } cred_src_e;
endpackage

// File: rtl/cred_slot.sv
// One back-end resource: stored free count with same-cycle update bypass
// and the signed credit that results after subtracting in-flight work.
module cred_slot #(
   parameter int CNT_W = 6,
   parameter int INIT  = 8,
   localparam int CR_W = CNT_W + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    upd_vld,
   input  logic [CNT_W-1:0]        upd_cnt,
   input  logic [CNT_W-1:0]        inflight,
   input  logic [CNT_W-1:0]        disp,
   output logic signed [CR_W-1:0]  credit
);
   logic [CNT_W-1:0]       free_q;
   logic [CNT_W-1:0]       free_eff;
   logic signed [CR_W-1:0] pend;

   always_ff @(posedge clk) begin
      if (!rst_n)       free_q <= CNT_W'(INIT);
      else if (upd_vld) free_q <= upd_cnt;
   end

   assign free_eff = upd_vld ? upd_cnt : free_q;
   assign pend     = $signed({2'b00, inflight}) - $signed({2'b00, disp});
   assign credit   = $signed({2'b00, free_eff}) - pend;
endmodule

// File: rtl/cred_pick.sv
// Minimum search with fixed tie-break, then grant clamp and width cap.
module cred_pick
   import cred_pkg::*;
#(
   parameter int CNT_W    = 6,
   parameter int RENAME_W = 4,
   localparam int CR_W    = CNT_W + 2,
   localparam int GNT_W   = $clog2(RENAME_W + 1)
) (
   input  logic signed [CR_W-1:0] credit [NUM_RES],
   input  logic [CNT_W-1:0]       avail,
   output logic [GNT_W-1:0]       grant,
   output logic                   block,
   output cred_src_e              src,
   output logic                   evt
);
   logic signed [CR_W-1:0] min_cr;
   logic signed [CR_W-1:0] avail_s;
   logic signed [CR_W-1:0] g_raw;
   logic signed [CR_W-1:0] g_cap;

   assign avail_s = $signed({2'b00, avail});

   always_comb begin
      min_cr = credit[0];
      src    = SRC_ROB;
      if (credit[1] < min_cr) begin
         min_cr = credit[1];
         src    = SRC_IQ;
      end
      if (credit[2] < min_cr) begin
         min_cr = credit[2];
         src    = SRC_LSQ;
      end
   end

   always_comb begin
      evt   = 1'b0;
      g_raw = avail_s;
      if (avail != '0) begin
         if (min_cr <= 0) begin
            g_raw = '0;
            evt   = 1'b1;
         end else if (min_cr < avail_s) begin
            g_raw = min_cr;
            evt   = 1'b1;
         end
      end
      g_cap = (g_raw > $signed(CR_W'(RENAME_W))) ? $signed(CR_W'(RENAME_W)) : g_raw;
   end

   assign grant = GNT_W'(g_cap);
   assign block = (g_cap < avail_s);
endmodule

// File: rtl/cred_inflight.sv
// Renamed-but-not-dispatched counter with underflow clamp.
module cred_inflight #(
   parameter int CNT_W = 6,
   parameter int GNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GNT_W-1:0] grant,
   input  logic [CNT_W-1:0] disp,
   output logic [CNT_W-1:0] count,
   output logic             underflow
);
   logic [CNT_W+1:0] sum;
   logic [CNT_W+1:0] disp_x;
   logic [CNT_W+1:0] diff;

   assign sum       = {2'b00, count} + (CNT_W+2)'(grant);
   assign disp_x    = {2'b00, disp};
   assign underflow = (sum < disp_x);
   assign diff      = sum - disp_x;

   always_ff @(posedge clk) begin
      if (!rst_n)         count <= '0;
      else if (underflow) count <= '0;
      else                count <= CNT_W'(diff);
   end
endmodule

// File: rtl/cred_limiter.sv
module cred_limiter
   import cred_pkg::*;
#(
   parameter int CNT_W    = 6,
   parameter int RENAME_W = 4,
   parameter int ROB_INIT = 32,
   parameter int IQ_INIT  = 16,
   parameter int LSQ_INIT = 8,
   parameter int EVT_W    = 16,
   parameter bit EVT_SAT  = 1'b1,
   localparam int CR_W    = CNT_W + 2,
   localparam int GNT_W   = $clog2(RENAME_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rob_upd_vld,
   input  logic [CNT_W-1:0] rob_upd_cnt,
   input  logic             rob_upd_empty,
   input  logic             iq_upd_vld,
   input  logic [CNT_W-1:0] iq_upd_cnt,
   input  logic             lsq_upd_vld,
   input  logic [CNT_W-1:0] lsq_upd_cnt,
   input  logic [CNT_W-1:0] disp_cnt,
   input  logic [CNT_W-1:0] disp_lsq_cnt,
   input  logic [CNT_W-1:0] avail_cnt,
   output logic [GNT_W-1:0] grant_cnt,
   output logic             block,
   output logic [1:0]       lim_src,
   output logic             rob_empty,
   output logic [CNT_W-1:0] inflight,
   output logic [EVT_W-1:0] rob_full_evt,
   output logic [EVT_W-1:0] iq_full_evt,
   output logic [EVT_W-1:0] lsq_full_evt,
   output logic             underflow_err
);
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W must be at least 2");
   end
   if (RENAME_W < 1 || RENAME_W >= (1 << CNT_W)) begin : g_bad_width
      $error("RENAME_W out of range for CNT_W");
   end
   if (ROB_INIT >= (1 << CNT_W) || IQ_INIT >= (1 << CNT_W) || LSQ_INIT >= (1 << CNT_W)) begin : g_bad_init
      $error("initial free counts must fit CNT_W");
   end
   if (EVT_W < 1) begin : g_bad_evt_w
      $error("EVT_W must be positive");
   end

   localparam int INIT_TAB [NUM_RES] = '{ROB_INIT, IQ_INIT, LSQ_INIT};

   logic                   upd_v   [NUM_RES];
   logic [CNT_W-1:0]       upd_c   [NUM_RES];
   logic [CNT_W-1:0]       disp_r  [NUM_RES];
   logic signed [CR_W-1:0] credit  [NUM_RES];
   logic [EVT_W-1:0]       evt_q   [NUM_RES];
   cred_src_e              pick_src;
   logic                   pick_evt;

   assign upd_v  = '{rob_upd_vld, iq_upd_vld, lsq_upd_vld};
   assign upd_c  = '{rob_upd_cnt, iq_upd_cnt, lsq_upd_cnt};
   assign disp_r = '{disp_cnt, disp_cnt, disp_lsq_cnt};

   for (genvar r = 0; r < NUM_RES; r++) begin : g_slot
      cred_slot #(.CNT_W(CNT_W), .INIT(INIT_TAB[r])) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .upd_vld  (upd_v[r]),
         .upd_cnt  (upd_c[r]),
         .inflight (inflight),
         .disp     (disp_r[r]),
         .credit   (credit[r])
      );
   end

   cred_pick #(.CNT_W(CNT_W), .RENAME_W(RENAME_W)) u_pick (
      .credit (credit),
      .avail  (avail_cnt),
      .grant  (grant_cnt),
      .block  (block),
      .src    (pick_src),
      .evt    (pick_evt)
   );

   cred_inflight #(.CNT_W(CNT_W), .GNT_W(GNT_W)) u_infl (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant     (grant_cnt),
      .disp      (disp_cnt),
      .count     (inflight),
      .underflow (underflow_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)           rob_empty <= 1'b1;
      else if (rob_upd_vld) rob_empty <= rob_upd_empty;
   end

   for (genvar r = 0; r < NUM_RES; r++) begin : g_evt
      logic hit;
      assign hit = pick_evt && (pick_src == cred_src_e'(r));
      if (EVT_SAT) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                      evt_q[r] <= '0;
            else if (hit && evt_q[r] != '1) evt_q[r] <= evt_q[r] + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)   evt_q[r] <= '0;
            else if (hit) evt_q[r] <= evt_q[r] + 1'b1;
         end
      end
   end

   assign lim_src      = pick_src;
   assign rob_full_evt = evt_q[0];
   assign iq_full_evt  = evt_q[1];
   assign lsq_full_evt = evt_q[2];
endmodule

// File: rtl/cred_limiter_chk.sv
module cred_limiter_chk #(
   parameter int CNT_W    = 6,
   parameter int RENAME_W = 4,
   parameter int EVT_W    = 16,
   localparam int GNT_W   = $clog2(RENAME_W + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] avail_cnt,
   input logic [CNT_W-1:0] disp_cnt,
   input logic [GNT_W-1:0] grant_cnt,
   input logic             block,
   input logic [1:0]       lim_src,
   input logic [CNT_W-1:0] inflight,
   input logic             underflow_err,
   input logic [EVT_W-1:0] rob_full_evt,
   input logic [EVT_W-1:0] iq_full_evt,
   input logic [EVT_W-1:0] lsq_full_evt
);
   logic             seen;
   logic [CNT_W:0]   step_exp;

   always_ff @(posedge clk) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   assign step_exp = {1'b0, inflight} + (CNT_W+1)'(grant_cnt) - {1'b0, disp_cnt};

   a_r7_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
      grant_cnt <= GNT_W'(RENAME_W));

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (avail_cnt == '0) |-> (grant_cnt == '0 && !block));

   a_r6_grant_le_avail: assert property (@(posedge clk) disable iff (!rst_n)
      (CNT_W+1)'(grant_cnt) <= (CNT_W+1)'(avail_cnt));

   a_r5_block_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (avail_cnt != '0 && grant_cnt == '0) |-> block);

   a_r4_src_legal: assert property (@(posedge clk) disable iff (!rst_n)
      lim_src != 2'd3);

   a_r9_inflight_step: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !underflow_err) |=> (inflight == $past(step_exp[CNT_W-1:0])));

   a_r10_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && underflow_err) |=> (inflight == '0));

   a_r12_evt_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      seen |=> (rob_full_evt >= $past(rob_full_evt) &&
                iq_full_evt  >= $past(iq_full_evt) &&
                lsq_full_evt >= $past(lsq_full_evt)));
endmodule

bind cred_limiter cred_limiter_chk #(
   .CNT_W    (CNT_W),
   .RENAME_W (RENAME_W),
   .EVT_W    (EVT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .avail_cnt     (avail_cnt),
   .disp_cnt      (disp_cnt),
   .grant_cnt     (grant_cnt),
   .block         (block),
   .lim_src       (lim_src),
   .inflight      (inflight),
   .underflow_err (underflow_err),
   .rob_full_evt  (rob_full_evt),
   .iq_full_evt   (iq_full_evt),
   .lsq_full_evt  (lsq_full_evt)
);

// File: tb/sim_cred_limiter.sv
module sim_cred_limiter;
   localparam int CNT_W = 6;
   localparam int EVT_W = 4;
   localparam int GNT_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rob_upd_vld = 1'b0;
   logic [CNT_W-1:0] rob_upd_cnt = '0;
   logic             rob_upd_empty = 1'b0;
   logic             iq_upd_vld = 1'b0;
   logic [CNT_W-1:0] iq_upd_cnt = '0;
   logic             lsq_upd_vld = 1'b0;
   logic [CNT_W-1:0] lsq_upd_cnt = '0;
   logic [CNT_W-1:0] disp_cnt = '0;
   logic [CNT_W-1:0] disp_lsq_cnt = '0;
   logic [CNT_W-1:0] avail_cnt = '0;
   logic [GNT_W-1:0] grant_cnt;
   logic             block;
   logic [1:0]       lim_src;
   logic             rob_empty;
   logic [CNT_W-1:0] inflight;
   logic [EVT_W-1:0] rob_full_evt;
   logic [EVT_W-1:0] iq_full_evt;
   logic [EVT_W-1:0] lsq_full_evt;
   logic             underflow_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   cred_limiter #(.CNT_W(CNT_W), .RENAME_W(4), .ROB_INIT(32), .IQ_INIT(16),
                  .LSQ_INIT(8), .EVT_W(EVT_W), .EVT_SAT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .rob_upd_vld(rob_upd_vld), .rob_upd_cnt(rob_upd_cnt), .rob_upd_empty(rob_upd_empty),
      .iq_upd_vld(iq_upd_vld), .iq_upd_cnt(iq_upd_cnt),
      .lsq_upd_vld(lsq_upd_vld), .lsq_upd_cnt(lsq_upd_cnt),
      .disp_cnt(disp_cnt), .disp_lsq_cnt(disp_lsq_cnt), .avail_cnt(avail_cnt),
      .grant_cnt(grant_cnt), .block(block), .lim_src(lim_src), .rob_empty(rob_empty),
      .inflight(inflight), .rob_full_evt(rob_full_evt), .iq_full_evt(iq_full_evt),
      .lsq_full_evt(lsq_full_evt), .underflow_err(underflow_err)
   );

   typedef struct packed {
      bit       rv;  bit [5:0] rc; bit re;
      bit       iv;  bit [5:0] ic;
      bit       lv;  bit [5:0] lc;
      bit [5:0] d;   bit [5:0] dl; bit [5:0] av;
      bit [2:0] eg;  bit eb; bit [1:0] es;
      bit [5:0] ei;  bit ee; bit ere;
   } vec_t;

   localparam int NV = 18;
   // inputs: rv rc re iv ic lv lc d dl av | expected: grant block src inflight(before) err rob_empty(before)
   localparam vec_t TBL [NV] = '{
      '{0,0,0, 0,0,  0,0,  0,0,0, 0,0,2, 0,0,1},
      '{0,0,0, 0,0,  0,0,  0,0,3, 3,0,2, 0,0,1},
      '{0,0,0, 0,0,  0,0,  0,0,6, 4,1,2, 3,0,1},
      '{0,0,0, 0,0,  0,0,  2,1,2, 2,0,2, 7,0,1},
      '{0,0,0, 0,0,  0,0,  0,0,1, 1,0,2, 7,0,1},
      '{0,0,0, 0,0,  0,0,  0,0,2, 0,1,2, 8,0,1},
      '{0,0,0, 1,10, 1,20, 0,0,3, 2,1,1, 8,0,1},
      '{0,0,0, 0,0,  0,0,  0,0,3, 0,1,1, 10,0,1},
      '{1,10,0, 1,20, 0,0, 0,0,1, 0,1,0, 10,0,1},
      '{0,63,1, 0,0, 0,0,  4,4,2, 2,0,0, 10,0,0},
      '{0,0,0, 1,10, 1,10, 0,0,2, 2,0,0, 8,0,0},
      '{1,40,1, 0,0, 0,0,  0,0,1, 0,1,1, 10,0,0},
      '{0,0,0, 0,0,  0,0,  15,0,0, 0,0,2, 10,1,1},
      '{0,0,0, 0,0,  0,0,  0,0,0, 0,0,1, 0,0,1},
      '{0,0,0, 0,0,  0,0,  0,0,9, 4,1,1, 0,0,1},
      '{0,0,0, 0,0,  0,0,  0,0,0, 0,0,1, 4,0,1},
      '{0,0,0, 0,0,  1,2,  0,0,3, 0,1,2, 4,0,1},
      '{0,0,0, 0,0,  0,0,  0,0,0, 0,0,2, 4,0,1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      rob_upd_vld = 0; rob_upd_cnt = '0; rob_upd_empty = 0;
      iq_upd_vld = 0;  iq_upd_cnt = '0;
      lsq_upd_vld = 0; lsq_upd_cnt = '0;
      disp_cnt = '0; disp_lsq_cnt = '0; avail_cnt = '0;
   endtask

   initial begin
      idle_inputs();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: state held at reset
      chk("R1 inflight at reset", int'(inflight), 0);
      chk("R1 rob_empty at reset", int'(rob_empty), 1);
      chk("R1 events at reset", int'(rob_full_evt) + int'(iq_full_evt) + int'(lsq_full_evt), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         rob_upd_vld = TBL[i].rv; rob_upd_cnt = TBL[i].rc; rob_upd_empty = TBL[i].re;
         iq_upd_vld  = TBL[i].iv; iq_upd_cnt  = TBL[i].ic;
         lsq_upd_vld = TBL[i].lv; lsq_upd_cnt = TBL[i].lc;
         disp_cnt = TBL[i].d; disp_lsq_cnt = TBL[i].dl; avail_cnt = TBL[i].av;
         #2;
         chk("R2 R3 R5 R6 R7 R8 R11 grant", int'(grant_cnt), int'(TBL[i].eg));
         chk("R5 R6 R7 R8 block", int'(block), int'(TBL[i].eb));
         chk("R4 lim_src", int'(lim_src), int'(TBL[i].es));
         chk("R9 inflight", int'(inflight), int'(TBL[i].ei));
         chk("R10 underflow_err", int'(underflow_err), int'(TBL[i].ee));
         chk("R11 rob_empty", int'(rob_empty), int'(TBL[i].ere));
      end

      @(negedge clk);
      idle_inputs();
      #2;
      // R5 R6: events counted against the limiting resource only
      chk("R5 rob_full_evt", int'(rob_full_evt), 1);
      chk("R6 iq_full_evt", int'(iq_full_evt), 3);
      chk("R6 lsq_full_evt", int'(lsq_full_evt), 3);
      chk("R7 width-only cap left counters", int'(inflight), 4);

      // R12: LSQ credit stays at -2; keep stalling until the counter pins
      for (int k = 0; k < 15; k++) begin
         @(negedge clk);
         avail_cnt = 6'd1;
      end
      @(negedge clk);
      idle_inputs();
      #2;
      chk("R12 lsq_full_evt saturated", int'(lsq_full_evt), 15);
      chk("R12 rob_full_evt unchanged", int'(rob_full_evt), 1);

      // R1: reset mid-run restores everything
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      #2;
      chk("R1 inflight after reset", int'(inflight), 0);
      chk("R1 events after reset", int'(rob_full_evt) + int'(iq_full_evt) + int'(lsq_full_evt), 0);
      chk("R1 rob_empty after reset", int'(rob_empty), 1);
      rst_n = 1'b1;
      @(negedge clk);
      avail_cnt = 6'd9;
      #2;
      chk("R1 grant from initial counts", int'(grant_cnt), 4);
      chk("R1 lim_src from initial counts", int'(lim_src), 2);
      @(negedge clk);
      idle_inputs();
      #2;
      chk("R1 LSQ initial 8 below 9 counted", int'(lsq_full_evt), 1);
      chk("R9 inflight after first grant", int'(inflight), 4);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule